// File: doc/BRIEF.md
# Pipelined zero-wait-state synchronous SRAM

This block is a single-port synchronous static memory. Each word is 36 bits wide and is split into four 9-bit byte lanes. The depth is set by a parameter. Every command is registered on the rising clock edge. The data for a command presented in cycle N moves on the data bus in cycle N+2, and this holds for both directions. Reads and writes can therefore be interleaved in any order with no idle bus cycles. Write addresses are held in a two-stage pipeline until their data arrives. A read that hits a write still in flight returns that write's data, merged lane by lane.

A command is either a load or a burst advance. A load takes a new address and direction and resets a two-bit burst counter. An advance repeats the last loaded direction at the next address in the burst. The address order inside the burst is linear or interleaved, chosen when the burst is loaded. Three chip-select inputs support depth expansion. A clock enable freezes the whole pipeline. An output enable gates the driver without a clock. A snooze input blocks new commands and turns the driver off while the memory keeps its contents.

Top module: `zws_sram`

## Requirements
- R1: A read loaded or advanced in cycle N (with `clk_en_n` low) drives its word on `dq_out` with `dq_oe` high during cycle N+2, provided `oe_n` and `snooze` are low.
- R2: A write command in cycle N takes its data from `dq_in` during cycle N+2. `dq_oe` stays low in cycle N+2.
- R3: Reads and writes may alternate on consecutive cycles. A read issued one cycle after a write to the same address returns the written data.
- R4: `byte_wr_n[i]` low writes bits [9i+8:9i] of the word. A lane whose bit is high keeps its old contents. A read that hits a pending write sees the same lane-wise merge.
- R5: The chip is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A load cycle that is not selected is a no-op: nothing is written and nothing is driven.
- R6: `adv_ld`=1 repeats the last loaded direction. When `order_il`=0 at load time, address bits [1:0] step as (start+k) mod 4 and the upper bits are unchanged. An advance with no loaded burst (after reset or a deselect) is a no-op.
- R7: When `order_il`=1 at load time, address bits [1:0] step as start XOR k for k = 1, 2, 3.
- R8: `oe_n` high forces `dq_oe` low at once, without a clock edge. Read data already in the pipeline is still presented when `oe_n` returns low.
- R9: While `clk_en_n` is high, a rising edge changes no state: the command on the inputs is ignored, and pending reads and writes are delayed by one cycle.
- R10: While `snooze` is high, no command is accepted and `dq_oe` is low. The memory contents are kept.
- R11: While reset is asserted, `dq_oe` is low and all pending commands are dropped. Reset release is synchronized over two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable for all state |
| addr | input | ADDR_W | Word address sampled on load |
| adv_ld | input | 1 | 1 = advance burst, 0 = load new command |
| wr_n | input | 1 | 0 = write, 1 = read (load cycles) |
| byte_wr_n | input | 4 | Active-low write enable for each 9-bit lane |
| sel1_n | input | 1 | Active-low chip select |
| sel2 | input | 1 | Active-high chip select |
| sel3_n | input | 1 | Active-low chip select |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous active-low output enable |
| snooze | input | 1 | Low-power hold: blocks commands and the driver |
| dq_in | input | 36 | Write data from the bus |
| dq_out | output | 36 | Read data to the bus |
| dq_oe | output | 1 | Bus driver enable |

## Verification
A stage register that is skipped or duplicated moves read data one cycle early or late on `dq_out`. It also pairs a write with the wrong bus word. The read that follows such a write shows the error two cycles later. A wrong burst counter or order select shows up as an address swap once the burst is read back, about six cycles after the first write. A broken forwarding path shows up only when a read directly follows a write to the same word, which the bench exercises with a single-lane write. A clock enable or snooze that leaks through shows up as data appearing a cycle early, or as a stored word being overwritten.

// File: rtl/zws_pkg.sv
`timescale 1ns/1ps
package zws_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int CNT_W  = 2;

  typedef struct packed {
    logic             vld;
    logic             wr;
    logic [LANES-1:0] lane_we;
  } op_t;
endpackage

// File: rtl/zws_burst.sv
`timescale 1ns/1ps
module zws_burst
  import zws_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              adv,
  input  logic              sel_ok,
  input  logic              snooze,
  input  logic              wr_in,
  input  logic              il_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              cmd_vld,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic              act_q, act_d;
  logic              wr_q, wr_d;
  logic              il_q, il_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  lo_step;

  always_comb begin
    lo_step = il_q ? (base_q[CNT_W-1:0] ^ (cnt_q + 1'b1))
                   : (base_q[CNT_W-1:0] + (cnt_q + 1'b1));
  end

  // next-state: load, advance or hold
  always_comb begin
    act_d    = act_q;
    wr_d     = wr_q;
    il_d     = il_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    cmd_vld  = 1'b0;
    cmd_wr   = wr_q;
    cmd_addr = base_q;
    if (!snooze) begin
      if (!adv) begin
        act_d    = sel_ok;
        wr_d     = wr_in;
        il_d     = il_in;
        base_d   = addr_in;
        cnt_d    = '0;
        cmd_vld  = sel_ok;
        cmd_wr   = wr_in;
        cmd_addr = addr_in;
      end else if (act_q) begin
        cnt_d    = cnt_q + 1'b1;
        cmd_vld  = 1'b1;
        cmd_addr = {base_q[ADDR_W-1:CNT_W], lo_step};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      il_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      il_q   <= il_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R6: an accepted advance moves the counter by exactly one
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv && act_q && !snooze) |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R6: a load always restarts the burst at offset zero
  a_r6_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv && !snooze) |=> (cnt_q == '0));

  logic unused_hi;
  assign unused_hi = ^HI_W;
endmodule

// File: rtl/zws_wpipe.sv
`timescale 1ns/1ps
module zws_wpipe
  import zws_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  op_t               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  output op_t               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output op_t               s2_op,
  output logic [ADDR_W-1:0] s2_addr
);
  op_t               s1_q, s2_q;
  logic [ADDR_W-1:0] a1_q, a2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      a1_q <= '0;
      a2_q <= '0;
    end else if (en) begin
      s1_q <= in_op;
      a1_q <= in_addr;
      s2_q <= s1_q;
      a2_q <= a1_q;
    end
  end

  assign s1_op   = s1_q;
  assign s1_addr = a1_q;
  assign s2_op   = s2_q;
  assign s2_addr = a2_q;

  // R9: a disabled edge leaves both stages untouched
  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(s1_q) && $stable(s2_q) && $stable(a1_q) && $stable(a2_q)));

  // R2: a write in stage two is the one that sat in stage one an edge earlier
  a_r2_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (s2_q == $past(s1_q) && a2_q == $past(a1_q)));
endmodule

// File: rtl/zws_array.sv
`timescale 1ns/1ps
module zws_array
  import zws_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_lane,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_vld,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] mem_word;
  logic [WORD_W-1:0] merged;
  logic              hit;
  logic              vld_q;
  logic [WORD_W-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (en && wr_go) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_lane[i]) mem[wr_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
      end
    end
  end

  assign mem_word = mem[rd_addr];
  assign hit      = wr_go && (wr_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign merged[g*LANE_W +: LANE_W] = (hit && wr_lane[g]) ? wr_data[g*LANE_W +: LANE_W]
                                                             : mem_word[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (en) begin
      vld_q <= rd_go;
      if (rd_go) dat_q <= merged;
    end
  end

  assign rd_vld  = vld_q;
  assign rd_data = dat_q;

  // R1: an enabled read in stage one is presented after the next edge
  a_r1_read_out: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_go) |=> vld_q);
endmodule

// File: rtl/zws_sram.sv
`timescale 1ns/1ps
module zws_sram
  import zws_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adv_ld,
  input  logic              wr_n,
  input  logic [LANES-1:0]  byte_wr_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              order_il,
  input  logic              oe_n,
  input  logic              snooze,
  input  logic [WORD_W-1:0] dq_in,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe
);
  logic [1:0]        rst_sync;
  logic              rst_int;
  logic              en;
  logic              selected;
  logic              c_vld, c_wr;
  logic [ADDR_W-1:0] c_addr;
  op_t               in_op, s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic              rd_vld;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int = rst_sync[1];

  assign en       = !clk_en_n;
  assign selected = !sel1_n && sel2 && !sel3_n;

  zws_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_int),
    .en       (en),
    .adv      (adv_ld),
    .sel_ok   (selected),
    .snooze   (snooze),
    .wr_in    (!wr_n),
    .il_in    (order_il),
    .addr_in  (addr),
    .cmd_vld  (c_vld),
    .cmd_wr   (c_wr),
    .cmd_addr (c_addr)
  );

  always_comb begin
    in_op.vld     = c_vld;
    in_op.wr      = c_wr;
    in_op.lane_we = ~byte_wr_n;
  end

  zws_wpipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_int),
    .en      (en),
    .in_op   (in_op),
    .in_addr (c_addr),
    .s1_op   (s1_op),
    .s1_addr (s1_addr),
    .s2_op   (s2_op),
    .s2_addr (s2_addr)
  );

  zws_array #(.ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_int),
    .en      (en),
    .wr_go   (s2_op.vld && s2_op.wr),
    .wr_addr (s2_addr),
    .wr_lane (s2_op.lane_we),
    .wr_data (dq_in),
    .rd_go   (s1_op.vld && !s1_op.wr),
    .rd_addr (s1_addr),
    .rd_vld  (rd_vld),
    .rd_data (dq_out)
  );

  assign dq_oe = rd_vld && !oe_n && !snooze;

  // R10: snooze keeps every command out of the pipeline
  a_r10_snooze_blocks: assert property (@(posedge clk) disable iff (!rst_int)
    (en && snooze) |=> !s1_op.vld);

  // R5: an unselected load never enters the pipeline
  a_r5_deselect: assert property (@(posedge clk) disable iff (!rst_int)
    (en && !adv_ld && !selected) |=> !s1_op.vld);
endmodule

// File: tb/zws_sram_tb.sv
`timescale 1ns/1ps
module zws_sram_tb;
  localparam int    AW     = 6;
  localparam int    WW     = 36;
  localparam real   HALF   = 2.5;
  localparam int    WD_CYC = 200000;

  typedef struct packed {
    logic          sel;
    logic          adv;
    logic          wrn;
    logic [3:0]    ben;
    logic          il;
    logic [AW-1:0] a;
    logic [WW-1:0] din;
    logic          eoe;
    logic [WW-1:0] edat;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{1'b1,1'b0,1'b0,4'h0,1'b0,6'd4, 36'h0,         1'b0,36'h0},
    '{1'b1,1'b0,1'b0,4'h0,1'b0,6'd5, 36'h0,         1'b0,36'h0},
    '{1'b1,1'b0,1'b1,4'hF,1'b0,6'd4, 36'h100000004, 1'b0,36'h0},
    '{1'b1,1'b0,1'b1,4'hF,1'b0,6'd5, 36'h200000005, 1'b0,36'h0},
    '{1'b1,1'b0,1'b0,4'hE,1'b0,6'd4, 36'h0,         1'b1,36'h100000004},
    '{1'b1,1'b0,1'b1,4'hF,1'b0,6'd4, 36'h0,         1'b1,36'h200000005},
    '{1'b1,1'b0,1'b0,4'h0,1'b0,6'd6, 36'h333333333, 1'b0,36'h0},
    '{1'b1,1'b0,1'b1,4'hF,1'b0,6'd6, 36'h0,         1'b1,36'h100000133},
    '{1'b1,1'b0,1'b0,4'h0,1'b0,6'd9, 36'h444444444, 1'b0,36'h0},
    '{1'b1,1'b1,1'b0,4'h0,1'b0,6'd0, 36'h0,         1'b1,36'h444444444},
    '{1'b1,1'b1,1'b0,4'h0,1'b0,6'd0, 36'h500000009, 1'b0,36'h0},
    '{1'b1,1'b1,1'b0,4'h0,1'b0,6'd0, 36'h50000000A, 1'b0,36'h0},
    '{1'b1,1'b0,1'b1,4'hF,1'b1,6'd9, 36'h50000000B, 1'b0,36'h0},
    '{1'b1,1'b1,1'b1,4'hF,1'b0,6'd0, 36'h500000008, 1'b0,36'h0},
    '{1'b1,1'b1,1'b1,4'hF,1'b0,6'd0, 36'h0,         1'b1,36'h500000009},
    '{1'b1,1'b1,1'b1,4'hF,1'b0,6'd0, 36'h0,         1'b1,36'h500000008},
    '{1'b0,1'b0,1'b1,4'hF,1'b0,6'd0, 36'h0,         1'b1,36'h50000000B},
    '{1'b0,1'b0,1'b1,4'hF,1'b0,6'd0, 36'h0,         1'b1,36'h50000000A}
  };

  localparam logic [WW-1:0] X1 = 36'hABCDE1234;

  logic          clk;
  logic          rst_n;
  logic          clk_en_n;
  logic [AW-1:0] addr;
  logic          adv_ld;
  logic          wr_n;
  logic [3:0]    byte_wr_n;
  logic          sel1_n, sel2, sel3_n;
  logic          order_il;
  logic          oe_n;
  logic          snooze;
  logic [WW-1:0] dq_in;
  logic [WW-1:0] dq_out;
  logic          dq_oe;

  int n_chk;
  int n_fail;
  bit done;

  zws_sram #(.ADDR_W(AW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .addr      (addr),
    .adv_ld    (adv_ld),
    .wr_n      (wr_n),
    .byte_wr_n (byte_wr_n),
    .sel1_n    (sel1_n),
    .sel2      (sel2),
    .sel3_n    (sel3_n),
    .order_il  (order_il),
    .oe_n      (oe_n),
    .snooze    (snooze),
    .dq_in     (dq_in),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  task automatic check(input string req, input logic exp_oe, input logic [WW-1:0] exp_d,
                       input bit cmp_d);
    n_chk++;
    if (dq_oe !== exp_oe || (cmp_d && dq_out !== exp_d)) begin
      n_fail++;
      $display("FAIL %s: oe=%b dq=%h, expected oe=%b dq=%h", req, dq_oe, dq_out, exp_oe, exp_d);
    end
  endtask

  // drive one command cycle at the falling edge; outputs are then stable for checking
  task automatic step(input logic sel, input logic adv, input logic wrn, input logic [3:0] ben,
                      input logic il, input logic [AW-1:0] a, input logic [WW-1:0] din,
                      input logic ce_n, input logic snz);
    @(negedge clk);
    sel2      = sel;
    adv_ld    = adv;
    wr_n      = wrn;
    byte_wr_n = ben;
    order_il  = il;
    addr      = a;
    dq_in     = din;
    clk_en_n  = ce_n;
    snooze    = snz;
    #1;
  endtask

  task automatic nop(input logic [WW-1:0] din);
    step(1'b0, 1'b0, 1'b1, 4'hF, 1'b0, '0, din, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    step(1'b1, 1'b0, 1'b1, 4'hF, 1'b0, a, '0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; clk_en_n = 1'b0; addr = '0; adv_ld = 1'b0; wr_n = 1'b1;
    byte_wr_n = 4'hF; sel1_n = 1'b0; sel2 = 1'b0; sel3_n = 1'b0; order_il = 1'b0;
    oe_n = 1'b0; snooze = 1'b0; dq_in = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R11 reset state", 1'b0, '0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) nop('0);

    // R6: advance with no loaded burst is a no-op
    step(1'b1, 1'b1, 1'b1, 4'hF, 1'b0, '0, '0, 1'b0, 1'b0);
    nop('0);
    nop('0);
    check("R6 advance without load", 1'b0, '0, 1'b0);

    // vector table: alternation, forwarding, lanes, linear and interleaved bursts
    for (int i = 0; i < NV; i++) begin
      step(VT[i].sel, VT[i].adv, VT[i].wrn, VT[i].ben, VT[i].il, VT[i].a, VT[i].din,
           1'b0, 1'b0);
      check($sformatf("R1 R2 R3 R4 R6 R7 row %0d", i), VT[i].eoe, VT[i].edat, VT[i].eoe);
    end

    // R5: a deselected write leaves the stored word alone
    step(1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 6'd20, '0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 6'd20, '0, 1'b0, 1'b0);
    nop(X1);
    rd(6'd20);
    check("R5 deselected write drives nothing", 1'b0, '0, 1'b0);
    nop('0);
    nop('0);
    check("R5 deselected write ignored", 1'b1, X1, 1'b1);

    // R8: output enable works without a clock
    rd(6'd20);
    nop('0);
    nop('0);
    oe_n = 1'b1;
    #0.4;
    check("R8 oe_n high disables driver", 1'b0, '0, 1'b0);
    oe_n = 1'b0;
    #0.4;
    check("R8 data still presented", 1'b1, X1, 1'b1);

    // R9: clock enable freeze delays the read and drops the frozen command
    rd(6'd20);
    step(1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 6'd9, '0, 1'b1, 1'b0);
    check("R9 before frozen edge", 1'b0, '0, 1'b0);
    nop('0);
    check("R9 read delayed by freeze", 1'b0, '0, 1'b0);
    nop('0);
    check("R9 read after freeze", 1'b1, X1, 1'b1);
    nop('0);
    check("R9 frozen command ignored", 1'b0, '0, 1'b0);

    // R10: snooze blocks the driver and commands, contents retained
    rd(6'd20);
    nop('0);
    step(1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 6'd20, '0, 1'b0, 1'b1);
    check("R10 driver off in snooze", 1'b0, '0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 4'hF, 1'b0, '0, 36'h111111111, 1'b0, 1'b1);
    check("R10 driver off in snooze", 1'b0, '0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 6'd20, 36'h111111111, 1'b0, 1'b0);
    nop('0);
    nop('0);
    check("R10 contents retained", 1'b1, X1, 1'b1);

    // R11: reset drops a pending read
    rd(6'd20);
    nop('0);
    rst_n = 1'b0;
    #0.2;
    check("R11 reset asserted", 1'b0, '0, 1'b0);
    nop('0);
    check("R11 pending read dropped", 1'b0, '0, 1'b0);
    rst_n = 1'b1;
    repeat (3) nop('0);
    rd(6'd20);
    nop('0);
    nop('0);
    check("R11 R1 read after reset", 1'b1, X1, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule